// File: doc/BRIEF.md
# Register Write-Protection Unlock Sequencer

This block holds a small group of protected control registers behind a software key. Software writes three key bytes in a fixed order to one key address on a simple register bus. When the last byte arrives in the correct order, the block enters the unlocked state. The protected registers then accept writes. While the block stays locked, any write to a protected register is dropped and the old value remains.

The registered lock state can be read at the key address. It also drives a write-permission qualifier, which any protected register elsewhere on the chip must AND into its write enable. The block also contains one unprotected register. This register accepts every write, so the gated and ungated paths can be compared.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `unlocked` is 0, `prot_wr_ok` is 0, every protected register reads 0 and the open register reads 0.
- R2: The key address is 0x100. The key byte is `bus_wdata[7:0]`. Writing 0x59, then 0x16, then 0x88 to the key address sets `unlocked` to 1 one cycle after the 0x88 write. A read of the key address returns `unlocked` in bit 0 and 0 in all other bits.
- R3: While `unlocked` is 0, a write to a protected register (offsets 0x040 and 0x044, data in `bus_wdata[7:0]`) leaves its value unchanged.
- R4: `prot_wr_ok` equals `unlocked` in every cycle. While it is 1, a protected write takes effect on the next edge. This includes a write issued in the cycle directly after the 0x88 key write.
- R5: A key-address write that does not continue the sequence sends the tracker back to its start. A value of 0x59 always counts as the first key byte of a new attempt. For example, 59,59,16,88 and 59,16,59,16,88 both unlock, while 59,16,00,88 does not.
- R6: Writes to any address other than the key address, issued between key bytes, do not change the tracker's progress or the lock state.
- R7: While unlocked, a key-address write that is neither 0x59 nor the next expected key byte clears `unlocked` on the next edge. A write of 0x59 keeps the block unlocked.
- R8: The open register at offset 0x060 (data in `bus_wdata[7:0]`) takes every write, whether the block is locked or unlocked.
- R9: A read of a protected register or the open register returns its value zero-extended. A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| unlocked | output | 1 | Registered lock state, 1 when unlocked |
| prot_wr_ok | output | 1 | Write-permission qualifier for protected registers |
| prot_q | output | 16 | Contents of the two protected registers, register 0 in the low byte |
| open_q | output | 8 | Contents of the unprotected register |

## Verification
The embedded assertions check properties that hold on every cycle:
- A rise of the lock state is always preceded by a correct final key byte.
- A fall is always preceded by a breaking key-address write.
- The tracker and lock state never change without a key-address write.
- Protected registers stay stable while the block is locked and take the written data when it is unlocked.
- The open register always takes writes.

Some behaviour can only be shown by the bench's ordered scenarios:
- Which byte orders unlock the block, including restart on a repeated 0x59.
- That interleaved writes to other addresses leave the sequence intact.
- That a protected write in the cycle right after the last key byte succeeds.
- Zero-extended read-back.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam logic [7:0] KEY_B0 = 8'h59;
    localparam logic [7:0] KEY_B1 = 8'h16;
    localparam logic [7:0] KEY_B2 = 8'h88;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_GOT1 = 2'd1,
        TRK_GOT2 = 2'd2
    } trk_e;

    typedef struct packed {
        trk_e st;
        logic done;
        logic brk;
    } trk_step_t;

    function automatic trk_step_t key_step(trk_e s, logic [7:0] b);
        trk_step_t r;
        r.st   = TRK_IDLE;
        r.done = 1'b0;
        r.brk  = 1'b0;
        if (b == KEY_B0) begin
            r.st = TRK_GOT1;
        end else if (s == TRK_GOT1 && b == KEY_B1) begin
            r.st = TRK_GOT2;
        end else if (s == TRK_GOT2 && b == KEY_B2) begin
            r.done = 1'b1;
        end else begin
            r.brk = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/wp_key_tracker.sv
module wp_key_tracker
    import wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       unlocked
);

    trk_e      st_q;
    trk_step_t nxt;

    always_comb nxt = key_step(st_q, key_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= TRK_IDLE;
            unlocked <= 1'b0;
        end else if (key_wr) begin
            st_q <= nxt.st;
            if (nxt.done)
                unlocked <= 1'b1;
            else if (nxt.brk)
                unlocked <= 1'b0;
        end
    end

    // R2: unlocking only follows the final key byte written on top of step two
    a_r2_rise_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_wr && key_byte == KEY_B2 && st_q == TRK_GOT2));

    // R7: relock only follows a breaking key write
    a_r7_fall_needs_break: assert property (@(posedge clk) disable iff (rst)
        $fell(unlocked) |-> $past(key_wr && key_byte != KEY_B0));

    // R6: nothing moves without a key-address write
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !key_wr |=> ($stable(st_q) && $stable(unlocked)));

    a_r5_legal_state: assert property (@(posedge clk) disable iff (rst)
        st_q != 2'd3);

endmodule

// File: rtl/wp_prot_regs.sv
module wp_prot_regs #(
    parameter int N_PROT = 2,
    parameter int PROT_W = 8,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] PROT_BASE = 12'h040
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [PROT_W-1:0]        wdata,
    input  logic                     wr_ok,
    output logic [N_PROT*PROT_W-1:0] q,
    output logic                     hit,
    output logic [PROT_W-1:0]        rd_val
);

    localparam int STRIDE = 4;

    logic [N_PROT-1:0] sel;
    logic [PROT_W-1:0] regs [N_PROT];

    for (genvar i = 0; i < N_PROT; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = PROT_BASE + ADDR_W'(i * STRIDE);

        assign sel[i] = (addr == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && sel[i] && wr_ok)
                regs[i] <= wdata;
        end

        assign q[i*PROT_W +: PROT_W] = regs[i];

        // R3: a locked write is dropped
        a_r3_locked_hold: assert property (@(posedge clk) disable iff (rst)
            !wr_ok |=> $stable(regs[i]));

        // R4: an unlocked write lands on the next edge
        a_r4_unlocked_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel[i] && wr_ok) |=> regs[i] == $past(wdata));
    end

    assign hit = |sel;

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_PROT; i++)
            if (sel[i]) rd_val = regs[i];
    end

endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int N_PROT = 2,
    parameter int PROT_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h100,
    parameter logic [ADDR_W-1:0] PROT_BASE = 12'h040,
    parameter logic [ADDR_W-1:0] OPEN_ADDR = 12'h060
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     unlocked,
    output logic                     prot_wr_ok,
    output logic [N_PROT*PROT_W-1:0] prot_q,
    output logic [PROT_W-1:0]        open_q
);

    logic              key_sel;
    logic              open_sel;
    logic              prot_hit;
    logic [PROT_W-1:0] prot_rd;

    assign key_sel  = (bus_addr == KEY_ADDR);
    assign open_sel = (bus_addr == OPEN_ADDR);

    wp_key_tracker u_trk (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (bus_wr && key_sel),
        .key_byte (bus_wdata[7:0]),
        .unlocked (unlocked)
    );

    assign prot_wr_ok = unlocked;

    wp_prot_regs #(
        .N_PROT    (N_PROT),
        .PROT_W    (PROT_W),
        .ADDR_W    (ADDR_W),
        .PROT_BASE (PROT_BASE)
    ) u_prot (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata[PROT_W-1:0]),
        .wr_ok  (prot_wr_ok),
        .q      (prot_q),
        .hit    (prot_hit),
        .rd_val (prot_rd)
    );

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= '0;
        else if (bus_wr && open_sel)
            open_q <= bus_wdata[PROT_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (key_sel)
            bus_rdata[0] = unlocked;
        else if (prot_hit)
            bus_rdata[PROT_W-1:0] = prot_rd;
        else if (open_sel)
            bus_rdata[PROT_W-1:0] = open_q;
    end

    // R8: the open register ignores the lock
    a_r8_open_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && open_sel) |=> open_q == $past(bus_wdata[PROT_W-1:0]));

    // R2: upper bits of the key address read as zero
    a_r2_key_read_upper: assert property (@(posedge clk) disable iff (rst)
        key_sel |-> bus_rdata[DATA_W-1:1] == '0);

endmodule

// File: tb/wp_unlock_ctrl_tb_top.sv
module wp_unlock_ctrl_tb_top;

    localparam logic [11:0] A_KEY  = 12'h100;
    localparam logic [11:0] A_P0   = 12'h040;
    localparam logic [11:0] A_P1   = 12'h044;
    localparam logic [11:0] A_OPEN = 12'h060;
    localparam logic [11:0] A_NONE = 12'h104;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        unlocked;
    logic        prot_wr_ok;
    logic [15:0] prot_q;
    logic [7:0]  open_q;

    int n_tests = 0;
    int n_fail  = 0;

    logic       m_unl;
    int         m_step;
    logic [7:0] m_p0, m_p1, m_open;

    always #2.5 clk = ~clk;

    wp_unlock_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked(unlocked),
        .prot_wr_ok(prot_wr_ok), .prot_q(prot_q), .open_q(open_q)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_unl = 0; m_step = 0; m_p0 = 0; m_p1 = 0; m_open = 0;
    endtask

    function automatic int next_step(int s, logic [7:0] b);
        if (b == 8'h59) return 1;
        if (s == 1 && b == 8'h16) return 2;
        return 0;
    endfunction

    task automatic model_wr(logic [11:0] a, logic [7:0] d);
        if (a == A_KEY) begin
            if (d != 8'h59 && m_step == 2 && d == 8'h88) m_unl = 1;
            else if (d != 8'h59 && !(m_step == 1 && d == 8'h16)) m_unl = 0;
            m_step = next_step(m_step, d);
        end else if (a == A_P0) begin
            if (m_unl) m_p0 = d;
        end else if (a == A_P1) begin
            if (m_unl) m_p1 = d;
        end else if (a == A_OPEN) begin
            m_open = d;
        end
    endtask

    task automatic wr_cyc(logic [11:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        model_wr(a, d[7:0]);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic state_chk(string tag);
        #1;
        chk({tag, " unlocked"}, {31'd0, unlocked}, {31'd0, m_unl});
        chk("R4 qualifier", {31'd0, prot_wr_ok}, {31'd0, unlocked});
        chk({tag, " prot_q"}, {16'd0, prot_q}, {16'd0, m_p1, m_p0});
        chk("R8 open_q", {24'd0, open_q}, {24'd0, m_open});
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_wr = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic key3();
        wr_cyc(A_KEY, 32'h59); wr_cyc(A_KEY, 32'h16); wr_cyc(A_KEY, 32'h88);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R1: reset state
        state_chk("R1");
        rd_chk("R1 key read", A_KEY, 32'h0);
        rd_chk("R1 open read", A_OPEN, 32'h0);

        // R3: locked writes dropped; R8 open accepted
        wr_cyc(A_P0, 32'hA5); wr_cyc(A_P1, 32'h3C); wr_cyc(A_OPEN, 32'h77);
        state_chk("R3");
        rd_chk("R3 p0 read", A_P0, 32'h0);
        rd_chk("R8 open read", A_OPEN, 32'h77);

        // R2 + R4: unlock then write in the very next cycle
        key3();
        wr_cyc(A_P0, 32'hFFFF_FF5A);
        state_chk("R4");
        rd_chk("R2 key read", A_KEY, 32'h1);
        rd_chk("R9 p0 zero-ext", A_P0, 32'h5A);
        rd_chk("R9 unmapped", A_NONE, 32'h0);

        // R7: 0x59 keeps unlocked, other values relock
        wr_cyc(A_KEY, 32'h59);
        state_chk("R7 keep");
        wr_cyc(A_KEY, 32'h00);
        state_chk("R7 relock");
        wr_cyc(A_P1, 32'h11);
        state_chk("R3 after relock");

        // R5: restart patterns
        wr_cyc(A_KEY, 32'h59); key3();
        state_chk("R5 59,59,16,88");
        wr_cyc(A_KEY, 32'h01);
        wr_cyc(A_KEY, 32'h59); wr_cyc(A_KEY, 32'h16); key3();
        state_chk("R5 59,16,59,16,88");
        wr_cyc(A_KEY, 32'h01);
        wr_cyc(A_KEY, 32'h59); wr_cyc(A_KEY, 32'h16);
        wr_cyc(A_KEY, 32'h00); wr_cyc(A_KEY, 32'h88);
        state_chk("R5 broken");

        // R6: interleaved other-address writes
        wr_cyc(A_KEY, 32'h59); wr_cyc(A_OPEN, 32'h42);
        wr_cyc(A_KEY, 32'h16); wr_cyc(A_NONE, 32'h88); wr_cyc(A_P0, 32'h99);
        wr_cyc(A_KEY, 32'h88);
        state_chk("R6 interleave");
        rd_chk("R6 key read", A_KEY, 32'h1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int          k;
            logic [11:0] a;
            logic [31:0] d;
            k = $urandom_range(0, 9);
            case (k)
                0, 1, 2, 3: a = A_KEY;
                4: a = A_P0;
                5: a = A_P1;
                6: a = A_OPEN;
                default: a = A_NONE;
            endcase
            d = $urandom;
            if (a == A_KEY) begin
                case ($urandom_range(0, 4))
                    0: d[7:0] = 8'h59;
                    1: d[7:0] = 8'h16;
                    2: d[7:0] = 8'h88;
                    default: ;
                endcase
            end
            wr_cyc(a, d);
            if (i % 4 == 0) state_chk("R5 random");
        end
        rd_chk("R9 p1 read", A_P1, {24'd0, m_p1});

        do_reset();
        state_chk("R1 re-reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule